// File: doc/BRIEF.md
# Line Fetch Unit with Next-Line Predictor

This block sits at the front of an instruction pipeline and pulls instruction cache lines from a memory port one line at a time. It holds a fetch line address and a generation number. It sends the fetch line as a memory command and waits for the matching response. It then passes the response data downstream as a bundle. Each bundle carries the generation, the line address, the data and a guess at the line that comes next. After the downstream side takes a bundle, the fetch line moves to that guessed line.

The guess comes from a small direct-mapped table indexed by line address. On a hit the stored target is used. On a miss the guess is the next sequential line. A restart message from downstream does three things: it redirects fetch to a new line, it installs a new generation, and it teaches the table. When the redirect went somewhere other than the line it came from or the line after it, the table remembers that jump. When the redirect was the same line or the sequential line, the table forgets any jump stored for the line it came from.

Top module: `line_fetch_unit`

## Requirements
- R1: After a synchronous reset the generation is 0, the fetch line is 0, no request is pending (command valid high, command line 0) and every table entry is invalid. The restart port is always ready.
- R2: At most one memory request is outstanding. After a command handshake with no restart in the same cycle, command valid stays low until a bundle is taken or a restart arrives.
- R3: The command line address always equals the current fetch line address.
- R4: A bundle is offered only while a request is pending, a response is valid and its line address equals the fetch line. The bundle carries the current generation, the fetch line and the response data. While the bundle output is not ready, that response is held (response ready low).
- R5: While a request is pending, a response whose line address differs from the fetch line is consumed with no bundle, and the request stays pending.
- R6: While no request is pending, every response is consumed (response ready high) and dropped, and the fetch state does not change.
- R7: On a table miss the predicted next line is the fetch line plus one. When a bundle is taken, the fetch line becomes the predicted next line and a new command for it is offered in the next cycle.
- R8: A restart loads the generation and the fetch line from the message and cancels any pending request, so that in the next cycle command valid is high with the new line.
- R9: A restart whose new line is neither the previous line nor the previous line plus one stores the new line as the target for the previous line. A later bundle at the previous line predicts that target.
- R10: A restart whose new line equals the previous line or the previous line plus one invalidates the entry for the previous line when that entry is tagged with it. A later bundle at that line predicts the sequential line.
- R11: A restart takes priority over a response in the same cycle. No bundle is offered, and the response is consumed and dropped.
- R12: The table has 2^PRED_IDX_W entries selected by the low line-address bits, and each entry is tagged with the remaining bits. A line that maps to a valid entry holding another line's tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_valid | input | 1 | Restart message valid |
| rs_ready | output | 1 | Restart accepted (always high) |
| rs_gen | input | GEN_W | New generation number |
| rs_new_line | input | LINE_W | Line address to fetch next |
| rs_prev_line | input | LINE_W | Line the redirect came from (training key) |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command accepted |
| cmd_line | output | LINE_W | Line address requested |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Memory response consumed |
| rsp_line | input | LINE_W | Line address of the response |
| rsp_data | input | DATA_W | Line data of the response |
| bun_valid | output | 1 | Bundle valid |
| bun_ready | input | 1 | Bundle accepted downstream |
| bun_gen | output | GEN_W | Bundle generation |
| bun_line | output | LINE_W | Bundle line address |
| bun_next | output | LINE_W | Predicted next line address |
| bun_data | output | DATA_W | Bundle line data |

## Verification
Bundle valid, the bundle fields and response ready are combinational. They are due in the same cycle as the response or restart that causes them. Command valid and command line come from registers and change one clock edge after a command handshake, a bundle handshake or a restart. The bench drives every input 1 ns after a rising edge, samples the combinational results 1 ns later in the same cycle, and samples the registered results after the next edge. A bench model of the fetch line, the generation and the table supplies every expected value.

// File: rtl/line_fetch_pkg.sv
package line_fetch_pkg;

    localparam int unsigned LINE_W_DEF     = 32;
    localparam int unsigned GEN_W_DEF      = 8;
    localparam int unsigned DATA_W_DEF     = 64;
    localparam int unsigned PRED_IDX_W_DEF = 4;

    // Request tracking state
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_state_e;

    // Predictor update carried by a restart
    typedef enum logic [1:0] {
        TRAIN_NONE  = 2'd0,
        TRAIN_WRITE = 2'd1,
        TRAIN_ERASE = 2'd2
    } train_op_e;

    // A redirect that lands on the same or the sequential line carries no jump worth keeping
    function automatic train_op_e classify_restart(
        input logic active,
        input logic lands_same,
        input logic lands_next
    );
        if (!active)
            return TRAIN_NONE;
        if (lands_same || lands_next)
            return TRAIN_ERASE;
        return TRAIN_WRITE;
    endfunction

endpackage

// File: rtl/lfp_predictor.sv
module lfp_predictor
    import line_fetch_pkg::*;
#(
    parameter int unsigned LINE_W = LINE_W_DEF,
    parameter int unsigned IDX_W  = PRED_IDX_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] lk_line,
    output logic [LINE_W-1:0] lk_next,
    input  train_op_e         tr_op,
    input  logic [LINE_W-1:0] tr_line,
    input  logic [LINE_W-1:0] tr_target
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_W   = LINE_W - IDX_W;

    logic              ent_valid  [ENTRIES];
    logic [TAG_W-1:0]  ent_tag    [ENTRIES];
    logic [LINE_W-1:0] ent_target [ENTRIES];

    logic [IDX_W-1:0] tr_idx;
    logic [TAG_W-1:0] tr_tag;
    assign tr_idx = tr_line[IDX_W-1:0];
    assign tr_tag = tr_line[LINE_W-1:IDX_W];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[e]  <= 1'b0;
                ent_tag[e]    <= '0;
                ent_target[e] <= '0;
            end else if (tr_idx == IDX_W'(e)) begin
                if (tr_op == TRAIN_WRITE) begin
                    ent_valid[e]  <= 1'b1;
                    ent_tag[e]    <= tr_tag;
                    ent_target[e] <= tr_target;
                end else if (tr_op == TRAIN_ERASE && ent_tag[e] == tr_tag) begin
                    ent_valid[e] <= 1'b0;
                end
            end
        end
    end

    logic [IDX_W-1:0] lk_idx;
    logic             lk_hit;
    assign lk_idx  = lk_line[IDX_W-1:0];
    assign lk_hit  = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_line[LINE_W-1:IDX_W]);
    assign lk_next = lk_hit ? ent_target[lk_idx] : lk_line + LINE_W'(1);

endmodule

// File: rtl/lfp_req_ctrl.sv
module lfp_req_ctrl
    import line_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic       complete,
    input  logic       cancel,
    output req_state_e state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= REQ_IDLE;
        else if (cancel || complete)
            state <= REQ_IDLE;
        else if (issue)
            state <= REQ_WAIT;
    end
endmodule

// File: rtl/line_fetch_unit.sv
module line_fetch_unit
    import line_fetch_pkg::*;
#(
    parameter int unsigned LINE_W     = LINE_W_DEF,
    parameter int unsigned GEN_W      = GEN_W_DEF,
    parameter int unsigned DATA_W     = DATA_W_DEF,
    parameter int unsigned PRED_IDX_W = PRED_IDX_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rs_valid,
    output logic              rs_ready,
    input  logic [GEN_W-1:0]  rs_gen,
    input  logic [LINE_W-1:0] rs_new_line,
    input  logic [LINE_W-1:0] rs_prev_line,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [LINE_W-1:0] cmd_line,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              bun_valid,
    input  logic              bun_ready,
    output logic [GEN_W-1:0]  bun_gen,
    output logic [LINE_W-1:0] bun_line,
    output logic [LINE_W-1:0] bun_next,
    output logic [DATA_W-1:0] bun_data
);
    logic [GEN_W-1:0]  cur_gen;
    logic [LINE_W-1:0] cur_line;
    logic [LINE_W-1:0] pred_next;
    req_state_e        req_state;
    train_op_e         train_op;

    logic pending, rsp_usable, issue, complete;

    assign pending    = (req_state == REQ_WAIT);
    assign rsp_usable = pending && !rs_valid && (rsp_line == cur_line);

    assign rs_ready  = 1'b1;
    assign cmd_valid = !pending;
    assign cmd_line  = cur_line;
    assign bun_valid = rsp_valid && rsp_usable;
    assign rsp_ready = !rsp_usable || bun_ready;
    assign bun_gen   = cur_gen;
    assign bun_line  = cur_line;
    assign bun_next  = pred_next;
    assign bun_data  = rsp_data;

    assign issue    = cmd_valid && cmd_ready;
    assign complete = bun_valid && bun_ready;

    assign train_op = classify_restart(rs_valid,
                                       rs_new_line == rs_prev_line,
                                       rs_new_line == rs_prev_line + LINE_W'(1));

    lfp_req_ctrl u_req (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .complete (complete),
        .cancel   (rs_valid),
        .state    (req_state)
    );

    lfp_predictor #(
        .LINE_W (LINE_W),
        .IDX_W  (PRED_IDX_W)
    ) u_pred (
        .clk       (clk),
        .rst       (rst),
        .lk_line   (cur_line),
        .lk_next   (pred_next),
        .tr_op     (train_op),
        .tr_line   (rs_prev_line),
        .tr_target (rs_new_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_gen  <= '0;
            cur_line <= '0;
        end else if (rs_valid) begin
            cur_gen  <= rs_gen;
            cur_line <= rs_new_line;
        end else if (complete) begin
            cur_line <= pred_next;
        end
    end

endmodule

// File: rtl/lfp_checker.sv
module lfp_checker #(
    parameter int unsigned LINE_W = 32,
    parameter int unsigned GEN_W  = 8,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              rs_valid,
    input logic              rs_ready,
    input logic [LINE_W-1:0] rs_new_line,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [LINE_W-1:0] cmd_line,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [LINE_W-1:0] rsp_line,
    input logic              bun_valid,
    input logic              bun_ready,
    input logic [LINE_W-1:0] bun_line,
    input logic [LINE_W-1:0] bun_next
);
    a_r1_restart_ready: assert property (@(posedge clk) disable iff (rst)
        rs_ready);

    a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !rs_valid) |=> !cmd_valid);

    a_r4_bundle_when_pending: assert property (@(posedge clk) disable iff (rst)
        bun_valid |-> (!cmd_valid && rsp_valid && rsp_line == bun_line));

    a_r6_idle_drops: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (rsp_ready && !bun_valid));

    a_r7_advance: assert property (@(posedge clk) disable iff (rst)
        (bun_valid && bun_ready && !rs_valid) |=> (cmd_valid && cmd_line == $past(bun_next)));

    a_r8_restart_loads: assert property (@(posedge clk) disable iff (rst)
        rs_valid |=> (cmd_valid && cmd_line == $past(rs_new_line)));

    a_r11_restart_wins: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> (!bun_valid && rsp_ready));
endmodule

bind line_fetch_unit lfp_checker #(
    .LINE_W (LINE_W),
    .GEN_W  (GEN_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rs_valid    (rs_valid),
    .rs_ready    (rs_ready),
    .rs_new_line (rs_new_line),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_line    (cmd_line),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_line    (rsp_line),
    .bun_valid   (bun_valid),
    .bun_ready   (bun_ready),
    .bun_line    (bun_line),
    .bun_next    (bun_next)
);

// File: tb/line_fetch_unit_bench.sv
`timescale 1ns/1ps
module line_fetch_unit_bench;
    localparam int unsigned LW = 32;
    localparam int unsigned GW = 8;
    localparam int unsigned DW = 64;
    localparam int unsigned IW = 4;
    localparam int unsigned NE = 1 << IW;

    logic          clk = 1'b0;
    logic          rst;
    logic          rs_valid, rs_ready;
    logic [GW-1:0] rs_gen;
    logic [LW-1:0] rs_new_line, rs_prev_line;
    logic          cmd_valid, cmd_ready;
    logic [LW-1:0] cmd_line;
    logic          rsp_valid, rsp_ready;
    logic [LW-1:0] rsp_line;
    logic [DW-1:0] rsp_data;
    logic          bun_valid, bun_ready;
    logic [GW-1:0] bun_gen;
    logic [LW-1:0] bun_line, bun_next;
    logic [DW-1:0] bun_data;

    always #5 clk = ~clk;

    line_fetch_unit #(.LINE_W(LW), .GEN_W(GW), .DATA_W(DW), .PRED_IDX_W(IW)) u_line_fetch_unit (
        .clk(clk), .rst(rst),
        .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_gen(rs_gen),
        .rs_new_line(rs_new_line), .rs_prev_line(rs_prev_line),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_line(cmd_line),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line), .rsp_data(rsp_data),
        .bun_valid(bun_valid), .bun_ready(bun_ready), .bun_gen(bun_gen),
        .bun_line(bun_line), .bun_next(bun_next), .bun_data(bun_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model of the fetch state and predictor
    bit               m_valid  [NE];
    logic [LW-IW-1:0] m_tag    [NE];
    logic [LW-1:0]    m_target [NE];
    logic [GW-1:0]    m_gen;
    logic [LW-1:0]    m_line;

    function automatic logic [LW-1:0] m_predict(input logic [LW-1:0] ln);
        int i = int'(ln[IW-1:0]);
        if (m_valid[i] && m_tag[i] == ln[LW-1:IW])
            return m_target[i];
        return ln + 1;
    endfunction

    function automatic logic [DW-1:0] line_data(input logic [LW-1:0] ln);
        return {ln ^ 32'hA5C3_0F1E, ~ln};
    endfunction

    task automatic m_train(input logic [LW-1:0] nl, input logic [LW-1:0] pl);
        int i = int'(pl[IW-1:0]);
        if (nl == pl || nl == pl + 1) begin
            if (m_tag[i] == pl[LW-1:IW]) m_valid[i] = 1'b0;
        end else begin
            m_valid[i] = 1'b1; m_tag[i] = pl[LW-1:IW]; m_target[i] = nl;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        rs_valid = 0; rs_gen = '0; rs_new_line = '0; rs_prev_line = '0;
        cmd_ready = 0; rsp_valid = 0; rsp_line = '0; rsp_data = '0; bun_ready = 0;
    endtask

    task automatic send_cmd();
        cmd_ready = 1; #1;
        chk("R3", "cmd_valid", 64'(cmd_valid), 64'd1);
        chk("R3", "cmd_line", 64'(cmd_line), 64'(m_line));
        tick(); cmd_ready = 0; #1;
        chk("R2", "cmd_valid after issue", 64'(cmd_valid), 64'd0);
    endtask

    task automatic take_bundle(input string req);
        logic [LW-1:0] exp_next = m_predict(m_line);
        rsp_valid = 1; rsp_line = m_line; rsp_data = line_data(m_line); bun_ready = 1; #1;
        chk("R4", "bun_valid", 64'(bun_valid), 64'd1);
        chk("R4", "bun_gen", 64'(bun_gen), 64'(m_gen));
        chk("R4", "bun_line", 64'(bun_line), 64'(m_line));
        chk("R4", "bun_data", bun_data, line_data(m_line));
        chk(req, "bun_next", 64'(bun_next), 64'(exp_next));
        tick(); rsp_valid = 0; bun_ready = 0; m_line = exp_next; #1;
        chk("R7", "cmd_valid after bundle", 64'(cmd_valid), 64'd1);
        chk("R7", "cmd_line advanced", 64'(cmd_line), 64'(m_line));
    endtask

    task automatic fetch_one(input string req);
        send_cmd();
        take_bundle(req);
    endtask

    task automatic restart(input logic [GW-1:0] g, input logic [LW-1:0] nl, input logic [LW-1:0] pl);
        rs_valid = 1; rs_gen = g; rs_new_line = nl; rs_prev_line = pl; #1;
        chk("R11", "no bundle on restart", 64'(bun_valid), 64'd0);
        tick(); rs_valid = 0; m_train(nl, pl); m_gen = g; m_line = nl; #1;
        chk("R8", "cmd_valid after restart", 64'(cmd_valid), 64'd1);
        chk("R8", "cmd_line after restart", 64'(cmd_line), 64'(nl));
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_target[i] = '0; end
        m_gen = '0; m_line = '0;
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0; #1;

        // R1: reset state
        chk("R1", "cmd_valid", 64'(cmd_valid), 64'd1);
        chk("R1", "cmd_line", 64'(cmd_line), 64'd0);
        chk("R1", "rs_ready", 64'(rs_ready), 64'd1);
        chk("R1", "bun_valid", 64'(bun_valid), 64'd0);

        // R6: response with nothing pending is dropped
        rsp_valid = 1; rsp_line = 32'd0; rsp_data = line_data(0); bun_ready = 1; #1;
        chk("R6", "rsp_ready idle", 64'(rsp_ready), 64'd1);
        chk("R6", "bun_valid idle", 64'(bun_valid), 64'd0);
        tick(); rsp_valid = 0; bun_ready = 0; #1;
        chk("R6", "cmd_valid unchanged", 64'(cmd_valid), 64'd1);
        chk("R6", "cmd_line unchanged", 64'(cmd_line), 64'd0);

        fetch_one("R1");   // gen 0 and empty table: predicts line 1

        // R5: mismatching response consumed, request stays pending
        send_cmd();
        rsp_valid = 1; rsp_line = m_line + 7; rsp_data = '1; bun_ready = 1; #1;
        chk("R5", "bun_valid mismatch", 64'(bun_valid), 64'd0);
        chk("R5", "rsp_ready mismatch", 64'(rsp_ready), 64'd1);
        tick(); rsp_valid = 0; #1;
        chk("R5", "still pending", 64'(cmd_valid), 64'd0);
        // R4: back-pressure holds a matching response
        rsp_valid = 1; rsp_line = m_line; rsp_data = line_data(m_line); bun_ready = 0; #1;
        chk("R4", "bun_valid held", 64'(bun_valid), 64'd1);
        chk("R4", "rsp_ready held", 64'(rsp_ready), 64'd0);
        tick(); #1;
        chk("R4", "bun_line stable", 64'(bun_line), 64'(m_line));
        rsp_valid = 0;
        take_bundle("R7");

        // R9: non-sequential redirect is learned
        restart(8'd3, 32'h40, 32'h05);
        restart(8'd4, 32'h05, 32'h30);
        fetch_one("R9");
        // R12: aliasing line with another tag misses
        restart(8'd5, 32'h15, 32'h14);
        fetch_one("R12");
        // R10: sequential redirect erases the entry
        restart(8'd6, 32'h06, 32'h05);
        restart(8'd7, 32'h05, 32'h99);
        fetch_one("R10");

        // R11: restart beats a matching response
        send_cmd();
        rsp_valid = 1; rsp_line = m_line; rsp_data = line_data(m_line); bun_ready = 1;
        rs_valid = 1; rs_gen = 8'd9; rs_new_line = 32'h20; rs_prev_line = m_line; #1;
        chk("R11", "bun_valid", 64'(bun_valid), 64'd0);
        chk("R11", "rsp_ready", 64'(rsp_ready), 64'd1);
        tick(); m_train(32'h20, m_line); m_gen = 8'd9; m_line = 32'h20;
        idle_inputs(); #1;
        chk("R11", "cmd_valid", 64'(cmd_valid), 64'd1);
        chk("R11", "cmd_line", 64'(cmd_line), 64'h20);
        fetch_one("R7");

        // Random mix of restarts and fetches
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 4 == 0) begin
                logic [LW-1:0] nl = LW'($urandom % 64);
                logic [LW-1:0] pl;
                case ($urandom % 3)
                    0: pl = nl;
                    1: pl = nl - 1;
                    default: pl = LW'($urandom % 64);
                endcase
                restart(GW'($urandom), nl, pl);
            end else begin
                fetch_one("R9");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule